// File: doc/BRIEF.md
# DDR2 Write Burst Data Launcher

This block sits on the controller side of a DDR2 memory interface. When a posted write command is issued, it schedules that write's four-beat payload so the beats leave the controller exactly one write latency later. The write latency is one cycle less than the read latency, and the read latency is the additive latency plus the CAS latency. The block works on a single-rate clock that carries two beats per cycle, one for the rising half and one for the falling half. For each data cycle it gives a strobe enable, a data enable, the even and odd beats for that cycle, and an index saying which pair of the burst is on the pins.

Several writes can be waiting for launch at the same time. Each accepted write enters a shift pipeline at the slot that matches its cycles-to-launch and moves one slot per cycle. A write needs two cycles on the bus, so writes issued every other cycle produce an unbroken stream of beats. A write that arrives one cycle after the last accepted write is flagged and dropped. A write issued while the latency inputs hold an unsupported setting is also flagged and dropped.

Top module: `wr_burst_launcher`

## Requirements
- R1: While reset is held, and in the first cycle after it, `dq_en`, `dqs_en` and `err` are low and `beat_idx` is 0. Reset discards every write waiting for launch.
- R2: The write latency is `al + cl - 1`. If a command is sampled at clock edge N, the first data cycle is the cycle that follows edge N+WL.
- R3: The payload is packed with beat j at bits `[DW*j +: DW]`. The first data cycle shows beat 0 on `dq_even`, beat 1 on `dq_odd` and `beat_idx` = 0. The second data cycle shows beat 2 on `dq_even`, beat 3 on `dq_odd` and `beat_idx` = 2.
- R4: `dq_en` and `dqs_en` are high in exactly the two data cycles of each burst and are equal in every cycle.
- R5: Commands sampled two edges apart give bursts with no idle cycle between them, and each burst carries its own payload.
- R6: A command sampled one edge after an accepted command is dropped, and `err` is high for the one cycle after that edge. A command sampled two edges after the last accepted command is accepted, even if a dropped command came in between.
- R7: A command sampled while `cl < 2`, `cl > MAX_CL` or `al > MAX_AL` is dropped and raises `err` for one cycle. No burst follows it.
- R8: Up to the full latency span of writes can wait at once. With the largest latency setting, several queued writes launch in issue order.
- R9: The smallest setting (`al` = 0, `cl` = 2, WL = 1) launches correctly, including back-to-back writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one command slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd | input | 1 | Write command strobe, sampled on the rising edge |
| al | input | AW | Additive latency setting |
| cl | input | CW | CAS latency setting |
| wr_data | input | 4*DW | Four-beat payload, beat j at bits [DW*j +: DW] |
| dqs_en | output | 1 | Strobe drive enable |
| dq_en | output | 1 | Data drive enable |
| beat_idx | output | 2 | Index of the even beat in this cycle (0 or 2) |
| dq_even | output | DW | Beat for the rising half of the cycle |
| dq_odd | output | DW | Beat for the falling half of the cycle |
| err | output | 1 | One-cycle pulse when a command is dropped |

## Verification
The no-collision property in the pipeline assumes that `al` and `cl` stay fixed while any write is waiting or bursting. If the latency dropped while a write was queued, a new write could land in an occupied slot. The stimulus therefore changes the latency settings only after the previous train of writes has fully drained. The no-overlap check in the output stage relies on the two-cycle command spacing, which the block enforces itself. The bench deliberately breaks that spacing only to exercise the drop path.

// File: rtl/wbl_pkg.sv
package wbl_pkg;
   localparam int BURST_LEN = 4;
   localparam int PAIRS     = BURST_LEN / 2;
   localparam int MIN_CL    = 2;
   localparam logic [1:0] IDX_FIRST  = 2'd0;
   localparam logic [1:0] IDX_SECOND = 2'd2;
endpackage

// File: rtl/wbl_spacing.sv
module wbl_spacing #(
   parameter int AW     = 3,
   parameter int CW     = 3,
   parameter int MAX_AL = 5,
   parameter int MAX_CL = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cmd,
   input  logic [AW-1:0] al,
   input  logic [CW-1:0] cl,
   output logic          accept,
   output logic          err
);
   logic lat_ok;
   logic acc_q;
   logic err_q;

   always_comb begin
      lat_ok = (32'(al) <= MAX_AL) && (32'(cl) >= wbl_pkg::MIN_CL) && (32'(cl) <= MAX_CL);
      accept = wr_cmd && lat_ok && !acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         acc_q <= accept;
         err_q <= wr_cmd && !accept;
      end
   end

   assign err = err_q;

   // R6: two accepted commands never sit on neighbouring edges
   assert_accept_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept);

   // R7: a command under a bad latency setting is never accepted
   assert_bad_latency_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && (32'(cl) < wbl_pkg::MIN_CL)) |-> !accept);
endmodule

// File: rtl/wbl_delay_line.sv
module wbl_delay_line #(
   parameter  int DEPTH = 10,
   parameter  int PW    = 32,
   localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ins_en,
   input  logic [IW-1:0] ins_idx,
   input  logic [PW-1:0] ins_data,
   output logic          head_vld,
   output logic [PW-1:0] head_data
);
   logic          vld [DEPTH];
   logic [PW-1:0] dat [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic          nxt_v;
      logic [PW-1:0] nxt_d;
      if (i == DEPTH - 1) begin : g_tail
         assign nxt_v = 1'b0;
         assign nxt_d = '0;
      end else begin : g_body
         assign nxt_v = vld[i+1];
         assign nxt_d = dat[i+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld[i] <= 1'b0;
            dat[i] <= '0;
         end else if (ins_en && ins_idx == IW'(i)) begin
            vld[i] <= 1'b1;
            dat[i] <= ins_data;
         end else begin
            vld[i] <= nxt_v;
            dat[i] <= nxt_d;
         end
      end
   end

   assign head_vld  = vld[0];
   assign head_data = dat[0];

   // slot that would shift into the insert position this edge
   logic next_occ;
   always_comb begin
      next_occ = 1'b0;
      for (int j = 0; j < DEPTH - 1; j++) begin
         if (ins_idx == IW'(j)) next_occ = vld[j+1];
      end
   end

   // R8: a queued write is never overwritten by a new one
   assert_no_slot_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !next_occ);

   assert_insert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> (32'(ins_idx) < DEPTH));
endmodule

// File: rtl/wbl_beat_mux.sv
module wbl_beat_mux #(
   parameter int DW         = 8,
   parameter bit DUP_STROBE = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             head_vld,
   input  logic [wbl_pkg::BURST_LEN*DW-1:0] head_data,
   output logic                             dq_en,
   output logic                             dqs_en,
   output logic [1:0]                       beat_idx,
   output logic [DW-1:0]                    dq_even,
   output logic [DW-1:0]                    dq_odd
);
   logic            second_q;
   logic [2*DW-1:0] hold_q;
   logic            en_q;
   logic            en_d;
   logic [1:0]      idx_q;
   logic [DW-1:0]   ev_q;
   logic [DW-1:0]   od_q;

   assign en_d = head_vld || second_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         second_q <= 1'b0;
         hold_q   <= '0;
         en_q     <= 1'b0;
         idx_q    <= wbl_pkg::IDX_FIRST;
         ev_q     <= '0;
         od_q     <= '0;
      end else begin
         en_q <= en_d;
         if (head_vld) begin
            ev_q     <= head_data[0 +: DW];
            od_q     <= head_data[DW +: DW];
            hold_q   <= head_data[2*DW +: 2*DW];
            second_q <= 1'b1;
            idx_q    <= wbl_pkg::IDX_FIRST;
         end else if (second_q) begin
            ev_q     <= hold_q[0 +: DW];
            od_q     <= hold_q[DW +: DW];
            second_q <= 1'b0;
            idx_q    <= wbl_pkg::IDX_SECOND;
         end else begin
            idx_q <= wbl_pkg::IDX_FIRST;
         end
      end
   end

   if (DUP_STROBE) begin : g_dup_strobe
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= 1'b0;
         else        s_q <= en_d;
      end
      assign dqs_en = s_q;
   end else begin : g_shared_strobe
      assign dqs_en = en_q;
   end

   assign dq_en    = en_q;
   assign beat_idx = idx_q;
   assign dq_even  = ev_q;
   assign dq_odd   = od_q;

   // R5: a new burst never starts while the second pair is still pending
   assert_no_burst_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      head_vld |-> !second_q);

   // R3: the first pair is always followed by the second pair
   assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_en && beat_idx == wbl_pkg::IDX_FIRST) |=> (dq_en && beat_idx == wbl_pkg::IDX_SECOND));

   // R4: the second pair only shows while the data enable is high
   assert_second_pair_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_idx == wbl_pkg::IDX_SECOND) |-> dq_en);
endmodule

// File: rtl/wr_burst_launcher.sv
module wr_burst_launcher #(
   parameter  int DW         = 8,
   parameter  int MAX_AL     = 5,
   parameter  int MAX_CL     = 6,
   parameter  bit DUP_STROBE = 1'b1,
   localparam int AW         = (MAX_AL > 0) ? $clog2(MAX_AL + 1) : 1,
   localparam int CW         = $clog2(MAX_CL + 1),
   localparam int DEPTH      = MAX_AL + MAX_CL - 1,
   localparam int IW         = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int PW         = wbl_pkg::BURST_LEN * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cmd,
   input  logic [AW-1:0] al,
   input  logic [CW-1:0] cl,
   input  logic [PW-1:0] wr_data,
   output logic          dqs_en,
   output logic          dq_en,
   output logic [1:0]    beat_idx,
   output logic [DW-1:0] dq_even,
   output logic [DW-1:0] dq_odd,
   output logic          err
);
   if (DW < 1) begin : g_bad_dw
      $error("wr_burst_launcher: DW must be at least 1");
   end
   if (MAX_AL < 0) begin : g_bad_al
      $error("wr_burst_launcher: MAX_AL must not be negative");
   end
   if (MAX_CL < wbl_pkg::MIN_CL) begin : g_bad_cl
      $error("wr_burst_launcher: MAX_CL below the minimum CAS latency");
   end

   logic          accept;
   logic [IW-1:0] ins_idx;
   logic          head_vld;
   logic [PW-1:0] head_data;

   // slot index = WL - 1 = al + cl - 2
   assign ins_idx = IW'(al) + IW'(cl) - IW'(2);

   wbl_spacing #(
      .AW(AW), .CW(CW), .MAX_AL(MAX_AL), .MAX_CL(MAX_CL)
   ) u_spacing (
      .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .al(al), .cl(cl),
      .accept(accept), .err(err)
   );

   wbl_delay_line #(
      .DEPTH(DEPTH), .PW(PW)
   ) u_delay (
      .clk(clk), .rst_n(rst_n), .ins_en(accept), .ins_idx(ins_idx),
      .ins_data(wr_data), .head_vld(head_vld), .head_data(head_data)
   );

   wbl_beat_mux #(
      .DW(DW), .DUP_STROBE(DUP_STROBE)
   ) u_mux (
      .clk(clk), .rst_n(rst_n), .head_vld(head_vld), .head_data(head_data),
      .dq_en(dq_en), .dqs_en(dqs_en), .beat_idx(beat_idx),
      .dq_even(dq_even), .dq_odd(dq_odd)
   );

   // R4: strobe and data enables agree every cycle
   assert_strobe_matches_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dqs_en == dq_en);

   // R3: every burst opens with the first beat pair
   assert_burst_opens_first_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_en) |-> (beat_idx == wbl_pkg::IDX_FIRST));
endmodule

// File: tb/tb_wr_burst_launcher.sv
`timescale 1ns/1ps
module tb_wr_burst_launcher;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_cmd_i = 1'b0;
   logic [2:0]    al_i = 3'd2;
   logic [2:0]    cl_i = 3'd3;
   logic [31:0]   wr_data_i = '0;
   logic          dqs_en, dq_en, err;
   logic [1:0]    beat_idx;
   logic [DW-1:0] dq_even, dq_odd;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   wr_burst_launcher dut (
      .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd_i), .al(al_i), .cl(cl_i),
      .wr_data(wr_data_i), .dqs_en(dqs_en), .dq_en(dq_en), .beat_idx(beat_idx),
      .dq_even(dq_even), .dq_odd(dq_odd), .err(err)
   );

   typedef struct packed {
      logic [2:0] al;
      logic [2:0] cl;
      logic [3:0] n;
   } vec_t;

   // R2 basic, R9 smallest, R5+R9 back-to-back at WL=1, R5 seamless,
   // R8 deepest queue, mixed, R8 long train
   localparam vec_t VEC [7] = '{
      '{3'd2, 3'd3, 4'd1},
      '{3'd0, 3'd2, 4'd1},
      '{3'd0, 3'd2, 4'd4},
      '{3'd2, 3'd3, 4'd3},
      '{3'd5, 3'd6, 4'd3},
      '{3'd1, 3'd4, 4'd2},
      '{3'd3, 3'd2, 4'd5}
   };

   function automatic logic [7:0] beat(input int burst, input int j, input int seed);
      return 8'(seed * 37 + burst * 16 + j + 1);
   endfunction

   function automatic logic [31:0] payload(input int burst, input int seed);
      return {beat(burst, 3, seed), beat(burst, 2, seed), beat(burst, 1, seed), beat(burst, 0, seed)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // check state after one edge: active pair number k (-1 = idle)
   task automatic chk_cycle(input int k, input int seed, input int first_burst);
      if (k < 0) begin
         chk("R4 idle dq_en", 32'(dq_en), 32'd0);
         chk("R4 idle dqs_en", 32'(dqs_en), 32'd0);
      end else begin
         int b = first_burst + k / 2;
         int h = k % 2;
         chk("R2 R4 dq_en", 32'(dq_en), 32'd1);
         chk("R4 dqs_en", 32'(dqs_en), 32'd1);
         chk("R3 beat_idx", 32'(beat_idx), 32'(h * 2));
         chk("R3 R5 dq_even", 32'(dq_even), 32'(beat(b, 2 * h, seed)));
         chk("R3 R5 dq_odd", 32'(dq_odd), 32'(beat(b, 2 * h + 1, seed)));
      end
   endtask

   task automatic run_train(input logic [2:0] a, input logic [2:0] c, input int n, input int seed);
      int wl = int'(a) + int'(c) - 1;
      int total = 2 * n + wl + 3;
      al_i = a;
      cl_i = c;
      for (int cyc = 0; cyc <= total; cyc++) begin
         if (cyc >= 1) begin
            int k = cyc - 1 - wl;
            chk_cycle((k >= 0 && k < 2 * n) ? k : -1, seed, 0);
            chk("R6 err quiet", 32'(err), 32'd0);
         end
         wr_cmd_i  = (cyc < 2 * n) && (cyc % 2 == 0);
         wr_data_i = payload(cyc / 2, seed);
         @(negedge clk);
      end
      wr_cmd_i = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 dq_en", 32'(dq_en), 32'd0);
      chk("R1 dqs_en", 32'(dqs_en), 32'd0);
      chk("R1 err", 32'(err), 32'd0);
      chk("R1 beat_idx", 32'(beat_idx), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release dq_en", 32'(dq_en), 32'd0);
      chk("R1 after release err", 32'(err), 32'd0);

      // table walk
      for (int i = 0; i < 7; i++) begin
         run_train(VEC[i].al, VEC[i].cl, int'(VEC[i].n), i + 1);
      end

      // R6: too-close command dropped, next one two edges after the kept one accepted
      al_i = 3'd2; cl_i = 3'd3;
      wr_cmd_i = 1'b1; wr_data_i = payload(0, 20);
      @(negedge clk);                          // after edge 0
      chk("R6 err after kept cmd", 32'(err), 32'd0);
      wr_cmd_i = 1'b1; wr_data_i = payload(0, 21);
      @(negedge clk);                          // after edge 1
      chk("R6 err after close cmd", 32'(err), 32'd1);
      wr_cmd_i = 1'b1; wr_data_i = payload(1, 20);
      @(negedge clk);                          // after edge 2
      chk("R6 err after spaced cmd", 32'(err), 32'd0);
      wr_cmd_i = 1'b0;
      @(negedge clk);                          // after edge 3
      for (int e = 4; e <= 9; e++) begin
         @(negedge clk);                       // after edge e-? aligned below
         chk_cycle((e - 4 < 4) ? e - 4 : -1, 20, 0);
      end

      // R7: unsupported latency settings are dropped with a flag
      for (int t = 0; t < 3; t++) begin
         al_i = (t == 2) ? 3'd6 : 3'd0;
         cl_i = (t == 0) ? 3'd1 : ((t == 1) ? 3'd7 : 3'd2);
         wr_cmd_i = 1'b1; wr_data_i = payload(0, 30 + t);
         @(negedge clk);
         wr_cmd_i = 1'b0;
         chk("R7 err on bad latency", 32'(err), 32'd1);
         for (int w = 0; w < 14; w++) begin
            @(negedge clk);
            chk("R7 no burst after bad latency", 32'(dq_en), 32'd0);
         end
      end

      // R1: reset discards a queued write
      al_i = 3'd2; cl_i = 3'd3;
      wr_cmd_i = 1'b1; wr_data_i = payload(0, 40);
      @(negedge clk);
      wr_cmd_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset mid-run dq_en", 32'(dq_en), 32'd0);
      rst_n = 1'b1;
      for (int w = 0; w < 8; w++) begin
         @(negedge clk);
         chk("R1 queued write discarded", 32'(dq_en), 32'd0);
      end

      summary();
   end
endmodule